// File: doc/BRIEF.md
# Script Instruction Sequencer

A single-issue sequencer that runs small scripts written in 16-bit instructions. It fetches one instruction per cycle from an instruction memory that sits beside it: it drives the program counter and reads the instruction word back in the same cycle. It holds eight 32-bit general registers, a one-bit T flag and one hardware loop unit. The supported instructions are:

- load-immediate, add-immediate and subtract-immediate;
- compare-equal-immediate and an unsigned greater-or-equal register compare;
- register move and a store to local data memory;
- branch-if-T-set and branch-if-T-clear;
- a zero-overhead loop and a halt instruction.

A store is presented on a one-cycle write strobe with an address and a data word, and the data memory that takes it lies outside the block.

The sequencer leaves reset idle with the program counter at zero. A pulse on the run input starts execution. The halt instruction stops the sequencer and raises a one-cycle done pulse. The program counter is left at the instruction that follows the halt, so the next run pulse resumes the script from that point. An instruction the decoder does not know changes no state except the program counter, and it sets a sticky error flag.

Top module: `dscript_seq`

## Requirements
- R1: After reset the sequencer is idle, the program counter is 0, and done, the illegal flag, the T flag and the store strobe are all 0. All general registers are 0.
- R2: Load-immediate `00001 d[2:0] k[7:0]` writes the zero-extended k to rd. Add-immediate `00011 d k` adds the zero-extended k to rd, and subtract-immediate `00100 d k` subtracts it, both modulo 2^32.
- R3: Move `00000 d 10001 s` copies rs to rd. Store `01011 d[10:8] disp[7:3] a[2:0]` pulses the store strobe for one cycle, with data rd and address ra+disp (the low 16 bits).
- R4: Compare-equal-immediate `01001 d k` sets T to 1 when rd equals the zero-extended k and to 0 otherwise. Add, subtract, load, move and store leave T unchanged.
- R5: The unsigned compare `00000 d 11011 s` sets T to 1 when rd is greater than or equal to rs as unsigned numbers, and clears it otherwise.
- R6: Branch `0x7D oo` is taken when T=1 and branch `0x7C oo` is taken when T=0. A taken branch jumps to its own address + 1 + the sign-extended 8-bit offset oo, in both directions. A branch that is not taken falls through to the next instruction.
- R7: Loop `0x78 n` at address P runs the n instructions at P+1..P+n as many times as the value of r0 at that moment, with no extra cycle between passes. Execution then continues at P+n+1.
- R8: A loop instruction that finds r0 equal to 0 skips its body and goes straight to P+n+1.
- R9: Halt `0x0300` stops execution, pulses done for exactly one cycle, and leaves the program counter at the halt's address + 1. The next run pulse resumes execution there, with the registers and T kept.
- R10: An undecoded instruction only advances the program counter and sets the illegal flag, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Start or resume pulse, taken while idle |
| instr_i | input | 16 | Instruction word at address pc_o |
| pc_o | output | 8 | Program counter (instruction fetch address) |
| busy_o | output | 1 | High while the script is executing |
| done_o | output | 1 | One-cycle pulse after a halt instruction |
| illegal_o | output | 1 | Sticky undecoded-instruction flag |
| t_flag_o | output | 1 | Current T flag |
| st_we_o | output | 1 | Store strobe for the data memory |
| st_addr_o | output | 16 | Store address |
| st_data_o | output | 32 | Store data |

## Verification
The checker watches several rules on every cycle:

- done lasts exactly one cycle and is never high while executing;
- an idle sequencer keeps its program counter and T flag, and never strobes a store;
- the illegal flag, once set, stays set.

Arithmetic results, compare outcomes, branch targets in both directions, loop pass counts, loop skipping and the resume point after a halt depend on the contents of each program. Only the bench's directed scripts can show those, through the stores and the done-time program counter they produce.

// File: rtl/dscript_seq.sv
module dscript_seq #(
  parameter int AW  = 8,
  parameter int XW  = 32,
  parameter int SAW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_i,
  input  logic [15:0]    instr_i,
  output logic [AW-1:0]  pc_o,
  output logic           busy_o,
  output logic           done_o,
  output logic           illegal_o,
  output logic           t_flag_o,
  output logic           st_we_o,
  output logic [SAW-1:0] st_addr_o,
  output logic [XW-1:0]  st_data_o
);
  logic [XW-1:0] rf [8];
  logic [AW-1:0] pc, lp_start, lp_end;
  logic [XW-1:0] lp_cnt;
  logic          lp_act, busy, t, done_q, ill_q;

  wire [4:0] op  = instr_i[15:11];
  wire [2:0] rd  = instr_i[10:8];
  wire [4:0] sub = instr_i[7:3];
  wire [2:0] ra  = instr_i[2:0];
  wire [7:0] k   = instr_i[7:0];
  wire [XW-1:0] kx = {{(XW-8){1'b0}}, k};
  wire [AW-1:0] kp = {{(AW-8){1'b0}}, k};
  wire [AW-1:0] ks = {{(AW-8){k[7]}}, k};

  wire is_ldi  = op == 5'b00001;
  wire is_addi = op == 5'b00011;
  wire is_subi = op == 5'b00100;
  wire is_cmpe = op == 5'b01001;
  wire is_st   = op == 5'b01011;
  wire is_mov  = op == 5'b00000 && sub == 5'b10001;
  wire is_cmph = op == 5'b00000 && sub == 5'b11011;
  wire is_halt = instr_i == 16'h0300;
  wire is_bt   = instr_i[15:8] == 8'h7D;
  wire is_bf   = instr_i[15:8] == 8'h7C;
  wire is_loop = instr_i[15:8] == 8'h78;
  wire legal   = is_ldi | is_addi | is_subi | is_cmpe | is_st | is_mov |
                 is_cmph | is_halt | is_bt | is_bf | is_loop;

  wire [AW-1:0] pc_seq = pc + 1'b1;
  wire          take   = (is_bt & t) | (is_bf & ~t);
  wire          skip   = rf[0] == '0 || k == 8'd0;
  wire          at_end = lp_act && pc == lp_end && !is_loop;

  logic [AW-1:0] pc_nxt;
  always_comb begin
    if (take)                          pc_nxt = pc_seq + ks;
    else if (is_loop)                  pc_nxt = skip ? pc_seq + kp : pc_seq;
    else if (at_end && lp_cnt != 'd1)  pc_nxt = lp_start;
    else                               pc_nxt = pc_seq;
  end

  logic          wr_en;
  logic [XW-1:0] wr_val;
  always_comb begin
    wr_en  = 1'b1;
    wr_val = '0;
    if (is_ldi)       wr_val = kx;
    else if (is_addi) wr_val = rf[rd] + kx;
    else if (is_subi) wr_val = rf[rd] - kx;
    else if (is_mov)  wr_val = rf[ra];
    else              wr_en  = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) rf[i] <= '0;
      pc <= '0; busy <= 1'b0; t <= 1'b0; done_q <= 1'b0; ill_q <= 1'b0;
      lp_act <= 1'b0; lp_start <= '0; lp_end <= '0; lp_cnt <= '0;
    end else begin
      done_q <= busy & is_halt;
      if (!busy) begin
        busy <= run_i;
      end else begin
        pc <= pc_nxt;
        if (is_halt) busy <= 1'b0;
        if (!legal) ill_q <= 1'b1;
        if (wr_en) rf[rd] <= wr_val;
        if (is_cmpe) t <= rf[rd] == kx;
        if (is_cmph) t <= rf[rd] >= rf[ra];
        if (is_loop) begin
          lp_act   <= !skip;
          lp_start <= pc_seq;
          lp_end   <= pc + kp;
          lp_cnt   <= rf[0];
        end else if (at_end && !take) begin
          if (lp_cnt == 'd1) lp_act <= 1'b0;
          else               lp_cnt <= lp_cnt - 1'b1;
        end
      end
    end
  end

  assign pc_o      = pc;
  assign busy_o    = busy;
  assign done_o    = done_q;
  assign illegal_o = ill_q;
  assign t_flag_o  = t;
  assign st_we_o   = busy & is_st;
  assign st_addr_o = rf[ra][SAW-1:0] + {{(SAW-5){1'b0}}, sub};
  assign st_data_o = rf[rd];
endmodule

// File: rtl/dscript_seq_chk.sv
module dscript_seq_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_i,
  input logic [AW-1:0] pc_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          illegal_o,
  input logic          t_flag_o,
  input logic          st_we_o
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R9
  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> !busy_o); // R9
  AST_IDLE_PC_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!busy_o && !run_i) |=> $stable(pc_o)); // R9
  AST_IDLE_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n) !busy_o |-> !st_we_o); // R3
  AST_IDLE_T_HELD: assert property (@(posedge clk) disable iff (!rst_n) !busy_o |=> $stable(t_flag_o)); // R4
  AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) illegal_o |=> illegal_o); // R10
endmodule

bind dscript_seq dscript_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_i(run_i), .pc_o(pc_o), .busy_o(busy_o),
  .done_o(done_o), .illegal_o(illegal_o), .t_flag_o(t_flag_o), .st_we_o(st_we_o)
);

// File: tb/tb_dscript_seq.sv
module tb_dscript_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_i = 1'b0;
  logic [15:0] instr;
  logic [7:0]  pc;
  logic        busy, done, illegal, tflag, st_we;
  logic [15:0] st_addr;
  logic [31:0] st_data;

  logic [15:0] rom [256];
  assign instr = rom[pc];

  always #(CLK_PERIOD/2) clk = ~clk;

  dscript_seq dut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .instr_i(instr), .pc_o(pc),
    .busy_o(busy), .done_o(done), .illegal_o(illegal), .t_flag_o(tflag),
    .st_we_o(st_we), .st_addr_o(st_addr), .st_data_o(st_data)
  );

  int checks = 0, errors = 0;
  int n_st;
  logic [15:0] log_a [16];
  logic [31:0] log_d [16];
  logic [7:0]  done_pc;

  function automatic logic [15:0] LDI(input logic [2:0] r, input logic [7:0] v);  return {5'b00001, r, v}; endfunction
  function automatic logic [15:0] ADDI(input logic [2:0] r, input logic [7:0] v); return {5'b00011, r, v}; endfunction
  function automatic logic [15:0] SUBI(input logic [2:0] r, input logic [7:0] v); return {5'b00100, r, v}; endfunction
  function automatic logic [15:0] CMPE(input logic [2:0] r, input logic [7:0] v); return {5'b01001, r, v}; endfunction
  function automatic logic [15:0] ST(input logic [2:0] r, input logic [4:0] d, input logic [2:0] a); return {5'b01011, r, d, a}; endfunction
  function automatic logic [15:0] MOV(input logic [2:0] r, input logic [2:0] s);  return {5'b00000, r, 5'b10001, s}; endfunction
  function automatic logic [15:0] CMPH(input logic [2:0] r, input logic [2:0] s); return {5'b00000, r, 5'b11011, s}; endfunction
  function automatic logic [15:0] BT(input logic [7:0] o);   return {8'h7D, o}; endfunction
  function automatic logic [15:0] BF(input logic [7:0] o);   return {8'h7C, o}; endfunction
  function automatic logic [15:0] LOOP(input logic [7:0] n); return {8'h78, n}; endfunction
  localparam logic [15:0] HALT = 16'h0300;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_rom();
    for (int i = 0; i < 256; i++) rom[i] = HALT;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; run_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_to_done(input string req);
    int n;
    n_st = 0;
    @(negedge clk); run_i = 1'b1;
    @(negedge clk); run_i = 1'b0;
    n = 0;
    while (!done && n < 500) begin
      if (st_we && n_st < 16) begin log_a[n_st] = st_addr; log_d[n_st] = st_data; n_st++; end
      @(negedge clk); n++;
    end
    chk({req, " done seen"}, {31'd0, done}, 32'd1);
    done_pc = pc;
    @(negedge clk);
    chk("R9 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset();
    clear_rom();
    do_reset();
    @(negedge clk);
    chk("R1 pc", {24'd0, pc}, 32'd0);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 illegal", {31'd0, illegal}, 32'd0);
    chk("R1 tflag", {31'd0, tflag}, 32'd0);
    chk("R1 st_we", {31'd0, st_we}, 32'd0);
  endtask

  task automatic t_arith();
    clear_rom();
    rom[0] = LDI(1, 8'hF0); rom[1] = ADDI(1, 8'h20);
    rom[2] = LDI(2, 8'd5);  rom[3] = SUBI(2, 8'd7);
    rom[4] = MOV(3, 1);     rom[5] = LDI(5, 8'h10);
    rom[6] = ST(3, 5'd3, 5); rom[7] = ST(2, 5'd0, 5); rom[8] = HALT;
    do_reset();
    run_to_done("R2");
    chk("R3 store count", n_st, 2);
    chk("R3 store addr ra+disp", {16'd0, log_a[0]}, 32'h13);
    chk("R2 addi/R3 mov data", log_d[0], 32'h110);
    chk("R3 store addr", {16'd0, log_a[1]}, 32'h10);
    chk("R2 subi wrap", log_d[1], 32'hFFFF_FFFE);
    chk("R9 pc after halt", {24'd0, done_pc}, 32'd9);
  endtask

  task automatic t_compare();
    clear_rom();
    rom[0] = LDI(0, 8'd7); rom[1] = CMPE(0, 8'd7); rom[2] = ADDI(0, 8'd1); rom[3] = HALT;
    rom[4] = CMPE(0, 8'd7); rom[5] = HALT;
    rom[6] = SUBI(2, 8'd1); rom[7] = CMPH(2, 0); rom[8] = HALT;
    rom[9] = CMPH(0, 2); rom[10] = HALT;
    rom[11] = CMPH(0, 0); rom[12] = ST(0, 5'd0, 1); rom[13] = HALT;
    do_reset();
    run_to_done("R4");
    chk("R4 equal sets T, addi keeps it", {31'd0, tflag}, 32'd1);
    chk("R9 resume point", {24'd0, done_pc}, 32'd4);
    run_to_done("R4");
    chk("R4 unequal clears T", {31'd0, tflag}, 32'd0);
    run_to_done("R5");
    chk("R5 unsigned big >= small", {31'd0, tflag}, 32'd1);
    run_to_done("R5");
    chk("R5 small < big clears T", {31'd0, tflag}, 32'd0);
    run_to_done("R5");
    chk("R5 equal operands set T", {31'd0, tflag}, 32'd1);
    chk("R9 registers kept across resume", log_d[0], 32'd8);
  endtask

  task automatic t_branch();
    clear_rom();
    rom[0] = LDI(0, 8'd1); rom[1] = CMPE(0, 8'd1); rom[2] = BT(8'd2);
    rom[3] = ST(0, 5'd1, 0); rom[4] = ST(0, 5'd1, 0);
    rom[5] = BF(8'd1); rom[6] = LDI(3, 8'h33); rom[7] = CMPE(3, 8'd0);
    rom[8] = BF(8'd2); rom[9] = HALT; rom[10] = HALT;
    rom[11] = ST(3, 5'd0, 0); rom[12] = ADDI(0, 8'd1); rom[13] = CMPE(0, 8'd3);
    rom[14] = BF(8'hFC); rom[15] = HALT;
    do_reset();
    run_to_done("R6");
    chk("R6 store count", n_st, 2);
    chk("R6 forward taken skip", {16'd0, log_a[0]}, 32'd1);
    chk("R6 data", log_d[0], 32'h33);
    chk("R6 backward branch", {16'd0, log_a[1]}, 32'd2);
    chk("R6 final pc", {24'd0, done_pc}, 32'd16);
  endtask

  task automatic t_loop();
    clear_rom();
    rom[0] = LDI(0, 8'd3); rom[1] = LDI(1, 8'd0); rom[2] = LOOP(8'd2);
    rom[3] = ADDI(1, 8'd5); rom[4] = ST(1, 5'd0, 2);
    rom[5] = ST(1, 5'd1, 2); rom[6] = HALT;
    do_reset();
    run_to_done("R7");
    chk("R7 store count", n_st, 4);
    chk("R7 pass1", log_d[0], 32'd5);
    chk("R7 pass2", log_d[1], 32'd10);
    chk("R7 pass3", log_d[2], 32'd15);
    chk("R7 exit store addr", {16'd0, log_a[3]}, 32'd1);
    chk("R7 pc after", {24'd0, done_pc}, 32'd7);
  endtask

  task automatic t_loop_zero();
    clear_rom();
    rom[0] = LDI(0, 8'd0); rom[1] = LOOP(8'd2);
    rom[2] = ST(0, 5'd0, 0); rom[3] = ST(0, 5'd0, 0);
    rom[4] = LDI(1, 8'd9); rom[5] = ST(1, 5'd2, 0); rom[6] = HALT;
    do_reset();
    run_to_done("R8");
    chk("R8 body skipped", n_st, 1);
    chk("R8 addr", {16'd0, log_a[0]}, 32'd2);
    chk("R8 data", log_d[0], 32'd9);
  endtask

  task automatic t_illegal();
    clear_rom();
    rom[0] = LDI(1, 8'd4); rom[1] = 16'hFFFF; rom[2] = ST(1, 5'd0, 1); rom[3] = HALT;
    do_reset();
    @(negedge clk);
    chk("R10 flag clear before", {31'd0, illegal}, 32'd0);
    run_to_done("R10");
    chk("R10 flag set", {31'd0, illegal}, 32'd1);
    chk("R10 no-op continues", n_st, 1);
    chk("R10 regs untouched", log_d[0], 32'd4);
    chk("R10 pc", {24'd0, done_pc}, 32'd4);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_arith();
    t_compare();
    t_branch();
    t_loop();
    t_loop_zero();
    t_illegal();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule